// File: doc/BRIEF.md
# Two-Device Diagnostic and Presence Coordinator

This block coordinates the two storage devices that share one cable during reset and during the diagnostic command. A strap input picks the role. In the device-1 role the block drives two active-low open-collector style lines. One announces presence and later activity. The other signals that the local self-test passed. In the device-0 role the block releases both lines and samples the other device's copies instead. Each sample is taken inside a timed window, which tells device 0 whether device 1 exists and whether it passed.

Device 0 then builds the byte that goes to its Error register. The byte is the local self-test code, with bit 7 set when device 1 was detected but never reported a pass. When no device 1 was seen at reset, device 0 does not wait for it and asks for device 1's status to be forced to zero. Every wait is measured in millisecond ticks from a strobe input. All limits are parameters, so short windows can be used in simulation. The self-test itself lies outside the block: it arrives as a code with a valid strobe.

Top module: `dual_dev_diag_coord`

## Requirements
- R1: After reset, busy is 1, done is 0, err_code is 01h, clr_dev1_req is 0 and pass_n_o is 1. In the device-1 role (role_dev1=1) pres_n_o is 0. In the device-0 role it is 1.
- R2: In the device-0 role, busy stays high for PRES_WAIT_MS ticks after reset. Device 1 counts as present only if pres_n_i was seen low inside that window. A later assertion does not count.
- R3: diag_start while busy is 0 makes busy read 1 on the next cycle. diag_start while busy is 1 is ignored.
- R4: In the device-0 role with device 1 present, a low pass_n_i seen after NEG_WAIT_MS ticks and before PASS_WAIT_MS ticks of the command marks a pass. err_code then equals the local code and clr_dev1_req is 0.
- R5: In the device-0 role with device 1 present and no pass inside the window, done comes only once PASS_WAIT_MS ticks have elapsed. err_code is the local code OR 80h (bit 7 set).
- R6: In the device-0 role, a low pass_n_i during the first NEG_WAIT_MS ticks after the command is not taken as a pass.
- R7: In the device-0 role with device 1 absent, done follows the local result without waiting for the pass window. err_code is the local code and clr_dev1_req is 1.
- R8: done, err_code and clr_dev1_req come from registers and are valid together for a single cycle. busy is 0 in that cycle, and clr_dev1_req is never 1 without done.
- R9: In the device-1 role, pass_n_o goes to 1 on the cycle after an accepted diag_start. A local result ends busy and pulses done. The code is passed through to err_code. pass_n_o goes low one cycle after busy falls, and only if the code is 01h.
- R10: In the device-1 role, pres_n_o is released to 1 on the cycle after cmd_accept, or once PRES_HOLD_MS ticks have elapsed since reset, whichever comes first. It then stays 1 until reset.
- R11: In the device-0 role, pass_n_o and pres_n_o are held at 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or software reset) |
| role_dev1 | input | 1 | Strap: 1 = device-1 role, 0 = device-0 role; changed only under reset |
| diag_start | input | 1 | One-cycle pulse: diagnostic command received |
| self_valid | input | 1 | One-cycle strobe: local self-test finished |
| self_code | input | 8 | Local self-test result code (01h = no error) |
| ms_tick | input | 1 | One-cycle enable per millisecond |
| cmd_accept | input | 1 | One-cycle pulse: first valid command accepted (device-1 role) |
| pass_n_i | input | 1 | Sampled pass-diagnostic line from device 1, active low |
| pres_n_i | input | 1 | Sampled presence/activity line from device 1, active low |
| pass_n_o | output | 1 | Pass-diagnostic line drive, active low, 1 = released |
| pres_n_o | output | 1 | Presence/activity line drive, active low, 1 = released |
| busy | output | 1 | Block is executing reset sequence or diagnostic |
| done | output | 1 | One-cycle completion pulse, doubles as interrupt request |
| err_code | output | 8 | Composed diagnostic code for the Error register |
| clr_dev1_req | output | 1 | Request to force device 1's status to 00h, valid with done |

## Verification
The checker tests these properties on every cycle:
- done is a single-cycle pulse, with busy low and any clear request aligned to it.
- An accepted start raises busy on the next cycle.
- In device-1 role, the pass line never falls while busy is high or on the cycle busy drops.
- The released presence line never returns to low.
- The device-0 role never drives its lines.
- A clear request never carries the failure bit.

Only the bench's scenarios can show that the code composition is right and that the windows are the right length:
- a pass at the late edge of the window;
- a pass just past the window;
- a stale early pass;
- a presence assertion after the reset window;
- presence release by command versus by timeout.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
   localparam int unsigned CODE_W = 8;
   localparam logic [CODE_W-1:0] CODE_OK        = 8'h01;
   localparam logic [CODE_W-1:0] CODE_RESET     = 8'h01;
   localparam logic [CODE_W-1:0] CODE_PEER_FAIL = 8'h80;

   typedef enum logic [1:0] {
      P0_WINDOW = 2'd0,
      P0_IDLE   = 2'd1,
      P0_DIAG   = 2'd2
   } p0_state_t;

   typedef enum logic {
      P1_TEST = 1'b0,
      P1_IDLE = 1'b1
   } p1_state_t;
endpackage

// File: rtl/ddc_tick_timer.sv
module ddc_tick_timer #(
   parameter  int unsigned LIMIT = 8,
   localparam int unsigned W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         tick,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] LIM_L = W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("ddc_tick_timer: LIMIT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (tick && cnt != LIM_L) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ddc_dev0_ctrl.sv
module ddc_dev0_ctrl
   import ddc_pkg::*;
#(
   parameter int unsigned PRES_WAIT_MS = 450,
   parameter int unsigned PASS_WAIT_MS = 5000,
   parameter int unsigned NEG_WAIT_MS  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              diag_start,
   input  logic              self_valid,
   input  logic [CODE_W-1:0] self_code,
   input  logic              ms_tick,
   input  logic              pass_n_i,
   input  logic              pres_n_i,
   output logic              busy,
   output logic              done,
   output logic [CODE_W-1:0] err_code,
   output logic              clr_req
);
   localparam int unsigned TLIM = (PRES_WAIT_MS > PASS_WAIT_MS) ? PRES_WAIT_MS : PASS_WAIT_MS;
   localparam int unsigned TW   = $clog2(TLIM + 1);
   localparam logic [TW-1:0] PRES_L = TW'(PRES_WAIT_MS);
   localparam logic [TW-1:0] PASS_L = TW'(PASS_WAIT_MS);
   localparam logic [TW-1:0] NEG_L  = TW'(NEG_WAIT_MS);

   p0_state_t         state;
   logic              peer_seen;
   logic              have_local;
   logic [CODE_W-1:0] local_code;
   logic              pass_seen;
   logic [TW-1:0]     cnt;
   logic              start_ok;
   logic              in_pass_win;
   logic              timed_out;

   assign start_ok    = (state == P0_IDLE) && diag_start;
   assign in_pass_win = (cnt >= NEG_L) && (cnt < PASS_L);
   assign timed_out   = (cnt >= PASS_L);
   assign busy        = (state != P0_IDLE);

   ddc_tick_timer #(.LIMIT(TLIM)) win_tmr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (start_ok),
      .tick (ms_tick),
      .cnt  (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= P0_WINDOW;
         peer_seen  <= 1'b0;
         have_local <= 1'b0;
         local_code <= '0;
         pass_seen  <= 1'b0;
         done       <= 1'b0;
         err_code   <= CODE_RESET;
         clr_req    <= 1'b0;
      end else begin
         done    <= 1'b0;
         clr_req <= 1'b0;
         unique case (state)
            P0_WINDOW: begin
               if (!pres_n_i)      peer_seen <= 1'b1;
               if (cnt >= PRES_L)  state     <= P0_IDLE;
            end
            P0_IDLE: begin
               if (diag_start) begin
                  state      <= P0_DIAG;
                  have_local <= 1'b0;
                  pass_seen  <= 1'b0;
               end
            end
            P0_DIAG: begin
               if (self_valid && !have_local) begin
                  have_local <= 1'b1;
                  local_code <= self_code;
               end
               if (!pass_n_i && in_pass_win) pass_seen <= 1'b1;
               if (have_local && (!peer_seen || pass_seen || timed_out)) begin
                  state    <= P0_IDLE;
                  done     <= 1'b1;
                  err_code <= local_code |
                              ((peer_seen && !pass_seen) ? CODE_PEER_FAIL : '0);
                  clr_req  <= !peer_seen;
               end
            end
            default: state <= P0_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ddc_dev1_ctrl.sv
module ddc_dev1_ctrl
   import ddc_pkg::*;
#(
   parameter int unsigned PRES_HOLD_MS = 31000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              diag_start,
   input  logic              self_valid,
   input  logic [CODE_W-1:0] self_code,
   input  logic              ms_tick,
   input  logic              cmd_accept,
   output logic              busy,
   output logic              done,
   output logic [CODE_W-1:0] err_code,
   output logic              pass_n_o,
   output logic              pres_n_o
);
   localparam int unsigned HW = $clog2(PRES_HOLD_MS + 1);
   localparam logic [HW-1:0] HOLD_L = HW'(PRES_HOLD_MS);

   p1_state_t     state;
   logic          pend_pass;
   logic [HW-1:0] hold_cnt;

   assign busy = (state == P1_TEST);

   ddc_tick_timer #(.LIMIT(PRES_HOLD_MS)) hold_tmr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (1'b0),
      .tick (ms_tick),
      .cnt  (hold_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= P1_TEST;
         pend_pass <= 1'b0;
         done      <= 1'b0;
         err_code  <= CODE_RESET;
         pass_n_o  <= 1'b1;
      end else begin
         done <= 1'b0;
         unique case (state)
            P1_TEST: begin
               if (self_valid) begin
                  state     <= P1_IDLE;
                  done      <= 1'b1;
                  err_code  <= self_code;
                  pend_pass <= (self_code == CODE_OK);
               end
            end
            P1_IDLE: begin
               if (diag_start) begin
                  state     <= P1_TEST;
                  pass_n_o  <= 1'b1;
                  pend_pass <= 1'b0;
               end else if (pend_pass) begin
                  pass_n_o  <= 1'b0;
                  pend_pass <= 1'b0;
               end
            end
            default: state <= P1_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              pres_n_o <= 1'b0;
      else if (cmd_accept || hold_cnt >= HOLD_L) pres_n_o <= 1'b1;
   end
endmodule

// File: rtl/dual_dev_diag_coord.sv
module dual_dev_diag_coord
   import ddc_pkg::*;
#(
   parameter int unsigned PRES_WAIT_MS = 450,
   parameter int unsigned PASS_WAIT_MS = 5000,
   parameter int unsigned NEG_WAIT_MS  = 1,
   parameter int unsigned PRES_HOLD_MS = 31000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       role_dev1,
   input  logic       diag_start,
   input  logic       self_valid,
   input  logic [7:0] self_code,
   input  logic       ms_tick,
   input  logic       cmd_accept,
   input  logic       pass_n_i,
   input  logic       pres_n_i,
   output logic       pass_n_o,
   output logic       pres_n_o,
   output logic       busy,
   output logic       done,
   output logic [7:0] err_code,
   output logic       clr_dev1_req
);
   if (NEG_WAIT_MS >= PASS_WAIT_MS) begin : g_bad_neg
      $error("dual_dev_diag_coord: NEG_WAIT_MS must be below PASS_WAIT_MS");
   end
   if (PRES_WAIT_MS < 1 || PRES_HOLD_MS < 1) begin : g_bad_win
      $error("dual_dev_diag_coord: windows must be at least one tick");
   end

   logic              d0_busy, d0_done, d0_clr;
   logic [CODE_W-1:0] d0_code;
   logic              d1_busy, d1_done, d1_pass_n, d1_pres_n;
   logic [CODE_W-1:0] d1_code;

   ddc_dev0_ctrl #(
      .PRES_WAIT_MS(PRES_WAIT_MS),
      .PASS_WAIT_MS(PASS_WAIT_MS),
      .NEG_WAIT_MS (NEG_WAIT_MS)
   ) dev0_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .diag_start(diag_start),
      .self_valid(self_valid),
      .self_code (self_code),
      .ms_tick   (ms_tick),
      .pass_n_i  (pass_n_i),
      .pres_n_i  (pres_n_i),
      .busy      (d0_busy),
      .done      (d0_done),
      .err_code  (d0_code),
      .clr_req   (d0_clr)
   );

   ddc_dev1_ctrl #(
      .PRES_HOLD_MS(PRES_HOLD_MS)
   ) dev1_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .diag_start(diag_start),
      .self_valid(self_valid),
      .self_code (self_code),
      .ms_tick   (ms_tick),
      .cmd_accept(cmd_accept),
      .busy      (d1_busy),
      .done      (d1_done),
      .err_code  (d1_code),
      .pass_n_o  (d1_pass_n),
      .pres_n_o  (d1_pres_n)
   );

   always_comb begin
      if (role_dev1) begin
         busy         = d1_busy;
         done         = d1_done;
         err_code     = d1_code;
         clr_dev1_req = 1'b0;
         pass_n_o     = d1_pass_n;
         pres_n_o     = d1_pres_n;
      end else begin
         busy         = d0_busy;
         done         = d0_done;
         err_code     = d0_code;
         clr_dev1_req = d0_clr;
         pass_n_o     = 1'b1;
         pres_n_o     = 1'b1;
      end
   end
endmodule

// File: rtl/ddc_checker.sv
module ddc_checker (
   input logic clk,
   input logic rst_n,
   input logic role_dev1,
   input logic diag_start,
   input logic busy,
   input logic done,
   input logic clr_dev1_req,
   input logic err_msb,
   input logic pass_n_o,
   input logic pres_n_o
);
   // R3
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_start && !busy) |=> busy);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R8
   clr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_dev1_req |-> done);

   // R7
   clr_no_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && clr_dev1_req) |-> !err_msb);

   // R9
   pass_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_dev1 && $fell(pass_n_o)) |-> (!busy && !$past(busy)));

   // R10
   pres_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role_dev1 && pres_n_o) |=> pres_n_o);

   // R11
   dev0_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !role_dev1 |-> (pass_n_o && pres_n_o));
endmodule

bind dual_dev_diag_coord ddc_checker chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .role_dev1   (role_dev1),
   .diag_start  (diag_start),
   .busy        (busy),
   .done        (done),
   .clr_dev1_req(clr_dev1_req),
   .err_msb     (err_code[7]),
   .pass_n_o    (pass_n_o),
   .pres_n_o    (pres_n_o)
);

// File: tb/dual_dev_diag_coord_tb_top.sv
module dual_dev_diag_coord_tb_top;
   localparam int PRES_W = 6;
   localparam int PASS_W = 20;
   localparam int NEG_W  = 2;
   localparam int HOLD_W = 30;

   typedef struct packed {
      logic       pres;
      logic [7:0] code;
      logic [7:0] on_t;
      logic [7:0] off_t;
      logic [7:0] exp_code;
      logic       exp_clr;
      logic       exp_late;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h01, 8'd5,   8'd255, 8'h01, 1'b0, 1'b0},  // R4 pass
      '{1'b1, 8'h03, 8'd255, 8'd255, 8'h83, 1'b0, 1'b1},  // R5 no pass
      '{1'b1, 8'h01, 8'd0,   8'd1,   8'h81, 1'b0, 1'b1},  // R6 stale pass
      '{1'b0, 8'h02, 8'd255, 8'd255, 8'h02, 1'b1, 1'b0},  // R7 absent
      '{1'b1, 8'h05, 8'd17,  8'd255, 8'h05, 1'b0, 1'b0},  // R4 late edge
      '{1'b1, 8'h04, 8'd22,  8'd255, 8'h84, 1'b0, 1'b1}   // R5 past window
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       role_dev1 = 1'b0;
   logic       diag_start = 1'b0;
   logic       self_valid = 1'b0;
   logic [7:0] self_code = 8'h00;
   logic       ms_tick = 1'b0;
   logic       cmd_accept = 1'b0;
   logic       pass_n_i = 1'b1;
   logic       pres_n_i = 1'b1;
   logic       pass_n_o, pres_n_o, busy, done, clr_dev1_req;
   logic [7:0] err_code;

   int n_tests = 0;
   int n_fail  = 0;
   int ncyc    = 0;
   int ticks   = 0;

   always #4 clk = ~clk;

   dual_dev_diag_coord #(
      .PRES_WAIT_MS(PRES_W),
      .PASS_WAIT_MS(PASS_W),
      .NEG_WAIT_MS (NEG_W),
      .PRES_HOLD_MS(HOLD_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .role_dev1(role_dev1), .diag_start(diag_start),
      .self_valid(self_valid), .self_code(self_code), .ms_tick(ms_tick),
      .cmd_accept(cmd_accept), .pass_n_i(pass_n_i), .pres_n_i(pres_n_i),
      .pass_n_o(pass_n_o), .pres_n_o(pres_n_o), .busy(busy), .done(done),
      .err_code(err_code), .clr_dev1_req(clr_dev1_req)
   );

   task automatic cyc();
      @(negedge clk);
      ncyc++;
      ms_tick = (ncyc % 4 == 0);
      if (ms_tick) ticks++;
   endtask

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      diag_start = 1'b0; self_valid = 1'b0; cmd_accept = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 200 && busy; k++) cyc();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int t0;
      int el;
      logic got;
      logic given;
      int el_done;
      logic [7:0] code_done;
      logic clr_done;

      // R1 / R11: reset state, device-0 role
      role_dev1 = 1'b0;
      pres_n_i = 1'b1;
      do_reset();
      t0 = ticks;
      cyc();
      chk(busy == 1'b1 && done == 1'b0 && clr_dev1_req == 1'b0, "R1 d0 busy/done/clr",
          {busy, done, clr_dev1_req}, 3'b100);
      chk(err_code == 8'h01, "R1 d0 err_code", err_code, 8'h01);
      chk(pass_n_o && pres_n_o, "R11 d0 lines released", {pass_n_o, pres_n_o}, 2'b11);

      // R3: start while busy (reset window) ignored
      diag_start = 1'b1; cyc(); diag_start = 1'b0;
      wait_idle();
      // R2: window length in ticks
      el = ticks - t0;
      chk(el >= PRES_W && el <= PRES_W + 1, "R2 window length", el, PRES_W);
      repeat (8) cyc();
      chk(busy == 1'b0, "R3 start ignored while busy", busy, 0);

      // R2: presence asserted after window does not count
      pres_n_i = 1'b0;
      cyc();
      diag_start = 1'b1; cyc(); diag_start = 1'b0;
      chk(busy == 1'b1, "R3 busy after start", busy, 1);
      self_code = 8'h01; self_valid = 1'b1; cyc(); self_valid = 1'b0;
      got = 1'b0; clr_done = 1'b0;
      for (int k = 0; k < 50 && !got; k++) begin
         if (done) begin got = 1'b1; clr_done = clr_dev1_req; end
         else cyc();
      end
      chk(got && clr_done, "R2 late presence treated absent", {got, clr_done}, 2'b11);
      pres_n_i = 1'b1;

      // Vector walk: device-0 composition cases
      for (int v = 0; v < NV; v++) begin
         role_dev1 = 1'b0;
         pass_n_i = 1'b1;
         pres_n_i = !VECS[v].pres;
         do_reset();
         cyc();
         wait_idle();
         pres_n_i = 1'b1;
         cyc();
         diag_start = 1'b1;
         t0 = ticks;
         cyc();
         diag_start = 1'b0;
         got = 1'b0; given = 1'b0;
         el_done = 0; code_done = '0; clr_done = 1'b0;
         for (int k = 0; k < 400 && !got; k++) begin
            if (done) begin
               got = 1'b1;
               el_done = ticks - t0;
               code_done = err_code;
               clr_done = clr_dev1_req;
               chk(!busy && pass_n_o && pres_n_o, "R8/R11 idle at done",
                   {busy, pass_n_o, pres_n_o}, 3'b011);
            end else begin
               el = ticks - t0;
               pass_n_i = !(el >= int'(VECS[v].on_t) && el < int'(VECS[v].off_t));
               self_valid = 1'b0;
               if (!given && el >= 3) begin
                  self_valid = 1'b1; self_code = VECS[v].code; given = 1'b1;
               end
               cyc();
            end
         end
         self_valid = 1'b0;
         pass_n_i = 1'b1;
         chk(got, "R4-R7 vector done", got, 1);
         chk(code_done == VECS[v].exp_code, "R4/R5/R6/R7 err_code", code_done, VECS[v].exp_code);
         chk(clr_done == VECS[v].exp_clr, "R7 clr_dev1_req", clr_done, VECS[v].exp_clr);
         chk((el_done >= PASS_W) == VECS[v].exp_late, "R5 timing of done", el_done, PASS_W);
         cyc();
         chk(done == 1'b0 && clr_dev1_req == 1'b0, "R8 one-cycle done", {done, clr_dev1_req}, 0);
      end

      // R1 / R9: device-1 role
      role_dev1 = 1'b1;
      do_reset();
      t0 = ticks;
      cyc();
      chk(busy && !done && pass_n_o && !pres_n_o, "R1 d1 reset lines",
          {busy, done, pass_n_o, pres_n_o}, 4'b1010);
      chk(err_code == 8'h01, "R1 d1 err_code", err_code, 8'h01);
      self_code = 8'h01; self_valid = 1'b1; cyc(); self_valid = 1'b0;
      chk(done && !busy && pass_n_o && err_code == 8'h01, "R9 busy drops before pass",
          {done, busy, pass_n_o}, 3'b101);
      cyc();
      chk(!pass_n_o && !done, "R9 pass asserted after busy", {pass_n_o, done}, 2'b00);
      diag_start = 1'b1; cyc(); diag_start = 1'b0;
      chk(busy && pass_n_o, "R9 pass negated on command", {busy, pass_n_o}, 2'b11);
      self_code = 8'h04; self_valid = 1'b1; cyc(); self_valid = 1'b0;
      chk(done && err_code == 8'h04 && !clr_dev1_req, "R9 fail code passthrough", err_code, 8'h04);
      repeat (3) cyc();
      chk(pass_n_o == 1'b1, "R9 no pass on failed test", pass_n_o, 1);

      // R10: release by command
      chk(pres_n_o == 1'b0, "R10 presence held before command", pres_n_o, 0);
      cmd_accept = 1'b1; cyc(); cmd_accept = 1'b0;
      chk(pres_n_o == 1'b1, "R10 release on command", pres_n_o, 1);
      repeat (6) cyc();
      chk(pres_n_o == 1'b1, "R10 stays released", pres_n_o, 1);

      // R10: release by timeout
      do_reset();
      t0 = ticks;
      while (ticks - t0 < HOLD_W - 5) cyc();
      chk(pres_n_o == 1'b0, "R10 held before hold limit", pres_n_o, 0);
      while (ticks - t0 < HOLD_W + 2) cyc();
      chk(pres_n_o == 1'b1, "R10 release on timeout", pres_n_o, 1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule